// File: doc/BRIEF.md
# Fixed-Priority Bus Request Multiplexer

This block lets several bus masters share one slave port. Each master drives a request/grant address channel (address, write flag, byte enables, write data) and receives a valid/data read response. In every cycle the block picks the requesting master with the lowest index and forwards its request to the slave. The slave's grant goes back only to that master. No register sits on the request path, so a request can be accepted in the same cycle it is raised.

A transfer is accepted on a rising clock edge when the slave sees its request line and its grant line both high. When the accepted transfer is a read, the block records which master issued it and blocks every master from the slave. The block stays blocked until the slave's response valid has been high at a rising edge. The response is steered only to the recorded master. Writes need no response tracking, so they never block later traffic. Requests go to the slave exactly as issued, with no address-range check.

Top module: `prio_bus_mux`

## Requirements
- R1: With reset held low and no master requesting, the slave request and every master grant and response valid are low. After reset is released, no read is outstanding, so the first request is forwarded at once.
- R2: While no read is outstanding, the slave request is high exactly when at least one master requests. The slave write flag, byte enables and write data are those of the requesting master with the lowest index.
- R3: Only the master selected by the arbiter sees grant high, and its grant equals the slave grant. Every other master sees grant low.
- R4: After a read is accepted (slave request, slave grant high, write flag low), the slave request and all master grants stay low. This holds up to and including the cycle of the first rising edge on which the slave response valid is high. Forwarding resumes in the next cycle.
- R5: While a read is outstanding, the slave response valid is passed only to the master whose read was accepted, and that master's read data equals the slave read data.
- R6: A slave response valid that arrives while no read is outstanding is ignored: every master sees response valid low.
- R7: An accepted write (write flag high) does not block anything. A waiting request is forwarded in the very next cycle.
- R8: The slave address equals the selected master's address for any 32-bit value, with no range check.
- R9: While master 0 requests continuously, the highest-index master is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| mReq | input | NUM_M | Request line of each master |
| mGnt | output | NUM_M | Grant line to each master |
| mAddr | input | NUM_M x ADDR_W | Address of each master |
| mWe | input | NUM_M | Write flag of each master (1 = write, 0 = read) |
| mBe | input | NUM_M x DATA_W/8 | Byte enables of each master |
| mWdata | input | NUM_M x DATA_W | Write data of each master |
| mRvalid | output | NUM_M | Response valid to each master |
| mRdata | output | NUM_M x DATA_W | Read data to each master |
| slvReq | output | 1 | Request to the slave |
| slvGnt | input | 1 | Grant from the slave |
| slvAddr | output | ADDR_W | Address to the slave |
| slvWe | output | 1 | Write flag to the slave |
| slvBe | output | DATA_W/8 | Byte enables to the slave |
| slvWdata | output | DATA_W | Write data to the slave |
| slvRvalid | input | 1 | Response valid from the slave |
| slvRdata | input | DATA_W | Read data from the slave |

## Verification
The bench builds the block with three masters and 32-bit address and data. With three masters the priority encoder has a lowest, a middle and a highest port, and the count is not a power of two, so starvation of the last port and middle-port selection can both occur. The 32-bit width lets random full-range addresses reach the slave. Phases of mixed traffic, writes only, and master 0 requesting continuously are compared each cycle against a behavioural model of the outstanding-read state. Spurious slave responses are injected while no read is outstanding.

// File: rtl/prio_bus_mux_pkg.sv
package prio_bus_mux_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic fwd;      // pass the selected request to the slave this cycle
    logic ldOwner;  // a read is accepted this cycle: record its master
    logic rspLive;  // a read is outstanding: route slave responses
  } muxStrobes_t;

endpackage

// File: rtl/prio_bus_mux_arb.sv
module prio_bus_mux_arb #(
  parameter int NUM_M = 3
) (
  input  logic [NUM_M-1:0] req,
  output logic [NUM_M-1:0] pickOh,
  output logic             anyReq
);

  // seen[i] is high when any master below index i requests
  logic [NUM_M:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < NUM_M; gi++) begin : g_chain
    assign seen[gi+1]  = seen[gi] | req[gi];
    assign pickOh[gi]  = req[gi] & ~seen[gi];
  end

  assign anyReq = seen[NUM_M];

endmodule

// File: rtl/prio_bus_mux_ctrl.sv
module prio_bus_mux_ctrl
  import prio_bus_mux_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyReq,
  input  logic        slvGnt,
  input  logic        selWe,
  input  logic        slvRvalid,
  output muxStrobes_t strobes
);

  logic readBusy;

  always_comb begin
    strobes.fwd     = anyReq & ~readBusy;
    strobes.ldOwner = anyReq & ~readBusy & slvGnt & ~selWe;
    strobes.rspLive = readBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        readBusy <= 1'b0;
    else if (strobes.ldOwner)         readBusy <= 1'b1;
    else if (readBusy && slvRvalid)   readBusy <= 1'b0;
  end

  // The outstanding flag only drops after a response edge
  AST_BUSY_CLEARS_ON_RSP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readBusy) |-> $past(slvRvalid)); // R4

  // The flag only rises after an accepted read
  AST_BUSY_SET_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readBusy) |-> $past(slvGnt && !selWe && anyReq)); // R4

endmodule

// File: rtl/prio_bus_mux_dp.sv
module prio_bus_mux_dp
  import prio_bus_mux_pkg::*;
#(
  parameter int NUM_M  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  muxStrobes_t                   strobes,
  input  logic [NUM_M-1:0]              pickOh,
  input  logic [NUM_M-1:0]              mReq,
  input  logic [NUM_M-1:0][ADDR_W-1:0]  mAddr,
  input  logic [NUM_M-1:0]              mWe,
  input  logic [NUM_M-1:0][BE_W-1:0]    mBe,
  input  logic [NUM_M-1:0][DATA_W-1:0]  mWdata,
  output logic [NUM_M-1:0]              mGnt,
  output logic [NUM_M-1:0]              mRvalid,
  output logic [NUM_M-1:0][DATA_W-1:0]  mRdata,
  input  logic                          slvGnt,
  input  logic                          slvRvalid,
  input  logic [DATA_W-1:0]             slvRdata,
  output logic                          slvReq,
  output logic [ADDR_W-1:0]             slvAddr,
  output logic                          slvWe,
  output logic [BE_W-1:0]               slvBe,
  output logic [DATA_W-1:0]             slvWdata
);

  logic [NUM_M-1:0] ownerOh;

  // AND-OR request multiplexer driven by the one-hot pick
  always_comb begin
    slvAddr  = '0;
    slvWe    = 1'b0;
    slvBe    = '0;
    slvWdata = '0;
    for (int i = 0; i < NUM_M; i++) begin
      if (pickOh[i]) begin
        slvAddr  = slvAddr  | mAddr[i];
        slvWe    = slvWe    | mWe[i];
        slvBe    = slvBe    | mBe[i];
        slvWdata = slvWdata | mWdata[i];
      end
    end
  end

  assign slvReq = strobes.fwd;

  always_comb begin
    mGnt    = (strobes.fwd && slvGnt) ? pickOh : '0;
    mRvalid = (strobes.rspLive && slvRvalid) ? ownerOh : '0;
  end

  for (genvar gi = 0; gi < NUM_M; gi++) begin : g_rdata
    assign mRdata[gi] = slvRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ownerOh <= '0;
    else if (strobes.ldOwner) ownerOh <= pickOh;
  end

  AST_GNT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mGnt)); // R3

  AST_GNT_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (|mGnt) |-> ((mReq & (mGnt - NUM_M'(1))) == '0)); // R2

  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ((mGnt & ~mReq) == '0)); // R3

  AST_RVALID_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(mRvalid)); // R5

  AST_RVALID_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (|mRvalid) |-> slvRvalid); // R6

endmodule

// File: rtl/prio_bus_mux.sv
module prio_bus_mux
  import prio_bus_mux_pkg::*;
#(
  parameter int NUM_M  = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_M-1:0]              mReq,
  output logic [NUM_M-1:0]              mGnt,
  input  logic [NUM_M-1:0][ADDR_W-1:0]  mAddr,
  input  logic [NUM_M-1:0]              mWe,
  input  logic [NUM_M-1:0][BE_W-1:0]    mBe,
  input  logic [NUM_M-1:0][DATA_W-1:0]  mWdata,
  output logic [NUM_M-1:0]              mRvalid,
  output logic [NUM_M-1:0][DATA_W-1:0]  mRdata,
  output logic                          slvReq,
  input  logic                          slvGnt,
  output logic [ADDR_W-1:0]             slvAddr,
  output logic                          slvWe,
  output logic [BE_W-1:0]               slvBe,
  output logic [DATA_W-1:0]             slvWdata,
  input  logic                          slvRvalid,
  input  logic [DATA_W-1:0]             slvRdata
);

  muxStrobes_t      strobes;
  logic [NUM_M-1:0] pickOh;
  logic             anyReq;

  prio_bus_mux_arb #(.NUM_M(NUM_M)) u_arb (
    .req    (mReq),
    .pickOh (pickOh),
    .anyReq (anyReq)
  );

  prio_bus_mux_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (anyReq),
    .slvGnt    (slvGnt),
    .selWe     (slvWe),
    .slvRvalid (slvRvalid),
    .strobes   (strobes)
  );

  prio_bus_mux_dp #(
    .NUM_M  (NUM_M),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pickOh    (pickOh),
    .mReq      (mReq),
    .mAddr     (mAddr),
    .mWe       (mWe),
    .mBe       (mBe),
    .mWdata    (mWdata),
    .mGnt      (mGnt),
    .mRvalid   (mRvalid),
    .mRdata    (mRdata),
    .slvGnt    (slvGnt),
    .slvRvalid (slvRvalid),
    .slvRdata  (slvRdata),
    .slvReq    (slvReq),
    .slvAddr   (slvAddr),
    .slvWe     (slvWe),
    .slvBe     (slvBe),
    .slvWdata  (slvWdata)
  );

  AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (slvReq && slvGnt && !slvWe) |=> !slvReq); // R4

  AST_WRITE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (slvReq && slvGnt && slvWe) |=> ((|mReq) == slvReq)); // R7

endmodule

// File: tb/prio_bus_mux_tb.sv
module prio_bus_mux_tb;

  localparam int NUM_M  = 3;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  logic                          clk = 1'b0;
  logic                          rstN;
  logic [NUM_M-1:0]              mReq;
  logic [NUM_M-1:0]              mGnt;
  logic [NUM_M-1:0][ADDR_W-1:0]  mAddr;
  logic [NUM_M-1:0]              mWe;
  logic [NUM_M-1:0][BE_W-1:0]    mBe;
  logic [NUM_M-1:0][DATA_W-1:0]  mWdata;
  logic [NUM_M-1:0]              mRvalid;
  logic [NUM_M-1:0][DATA_W-1:0]  mRdata;
  logic                          slvReq;
  logic                          slvGnt;
  logic [ADDR_W-1:0]             slvAddr;
  logic                          slvWe;
  logic [BE_W-1:0]               slvBe;
  logic [DATA_W-1:0]             slvWdata;
  logic                          slvRvalid;
  logic [DATA_W-1:0]             slvRdata;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  prio_bus_mux #(.NUM_M(NUM_M), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .mReq(mReq), .mGnt(mGnt), .mAddr(mAddr),
    .mWe(mWe), .mBe(mBe), .mWdata(mWdata), .mRvalid(mRvalid),
    .mRdata(mRdata), .slvReq(slvReq), .slvGnt(slvGnt), .slvAddr(slvAddr),
    .slvWe(slvWe), .slvBe(slvBe), .slvWdata(slvWdata),
    .slvRvalid(slvRvalid), .slvRdata(slvRdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model state
  bit busy  = 1'b0;
  int owner = 0;

  initial begin
    rstN = 1'b0;
    mReq = '0; mAddr = '0; mWe = '0; mBe = '0; mWdata = '0;
    slvGnt = 1'b0; slvRvalid = 1'b0; slvRdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check(slvReq == 1'b0, "R1 slvReq in reset", 64'(slvReq), 0);
    check(mGnt == '0, "R1 gnt in reset", 64'(mGnt), 0);
    check(mRvalid == '0, "R1 rvalid in reset", 64'(mRvalid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mReq = 3'b100; mWe = 3'b000; slvGnt = 1'b1;
    #1;
    check(slvReq == 1'b1, "R1 first request after reset", 64'(slvReq), 1);
    check(mGnt == 3'b100, "R1 first grant after reset", 64'(mGnt), 64'h4);
    mReq = '0; slvGnt = 1'b0;

    for (int cyc = 0; cyc < 2000; cyc++) begin
      int phase;
      int sel;
      bit anyR;
      bit expReq;
      logic [NUM_M-1:0] expGnt;
      logic [NUM_M-1:0] expRv;
      @(negedge clk);
      phase = cyc / 500;
      for (int i = 0; i < NUM_M; i++) begin
        mReq[i]   = (phase == 3) ? (($urandom % 4) == 0) : (($urandom % 2) == 0);
        mAddr[i]  = $urandom;
        mWe[i]    = (phase == 1) ? 1'b1 : 1'($urandom % 2);
        mBe[i]    = BE_W'($urandom);
        mWdata[i] = $urandom;
      end
      if (phase == 2) mReq[0] = 1'b1;
      slvGnt    = ($urandom % 4) != 0;
      slvRvalid = busy ? (($urandom % 3) == 0) : (($urandom % 6) == 0);
      slvRdata  = $urandom;
      #1;
      // expected values
      sel = -1;
      for (int i = NUM_M - 1; i >= 0; i--) if (mReq[i]) sel = i;
      anyR   = (sel >= 0);
      expReq = anyR && !busy;
      expGnt = (expReq && slvGnt) ? NUM_M'(1 << sel) : '0;
      expRv  = (busy && slvRvalid) ? NUM_M'(1 << owner) : '0;

      if (busy)
        check(slvReq == 1'b0 && mGnt == '0, "R4 blocked during read",
              64'({slvReq, mGnt}), 0);
      else
        check(slvReq == expReq, "R2 slvReq", 64'(slvReq), 64'(expReq));
      if (expReq) begin
        check(slvWe == mWe[sel], "R2 slvWe", 64'(slvWe), 64'(mWe[sel]));
        check(slvBe == mBe[sel], "R2 slvBe", 64'(slvBe), 64'(mBe[sel]));
        check(slvWdata == mWdata[sel], "R2 slvWdata", 64'(slvWdata), 64'(mWdata[sel]));
        check(slvAddr == mAddr[sel], "R8 slvAddr", 64'(slvAddr), 64'(mAddr[sel]));
      end
      check(mGnt == expGnt, "R3 grant vector", 64'(mGnt), 64'(expGnt));
      if (phase == 2)
        check(mGnt[NUM_M-1] == 1'b0, "R9 starved master", 64'(mGnt[NUM_M-1]), 0);
      if (busy) begin
        check(mRvalid == expRv, "R5 rvalid routing", 64'(mRvalid), 64'(expRv));
        if (slvRvalid)
          check(mRdata[owner] == slvRdata, "R5 rdata", 64'(mRdata[owner]), 64'(slvRdata));
      end else if (slvRvalid) begin
        check(mRvalid == '0, "R6 spurious rvalid", 64'(mRvalid), 0);
      end
      if (phase == 1 && !busy)
        check(slvReq == anyR, "R7 write does not block", 64'(slvReq), 64'(anyR));

      @(posedge clk);
      if (!busy && expReq && slvGnt && !mWe[sel]) begin
        busy  = 1'b1;
        owner = sel;
      end else if (busy && slvRvalid) begin
        busy = 1'b0;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrs);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      nErrs++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrs);
      $finish;
    end
  end

endmodule